// File: doc/BRIEF.md
# Four-Channel 8-bit PWM DAC with Open-Drain Pin Control

This block turns four 8-bit codes into four pulse-width modulated pin drives. A free-running 8-bit count advances once every `PRESCALE` system clocks, so one PWM period lasts 256 counts. While a channel is in converter mode, its pin is pulled low for as many counts of each period as its code says. The output of each channel is an active-low pull-down enable. A value of 1 means the driver is off and an external resistor holds the pin high.

Each channel has a data register, which a load strobe writes, and a shadow register that the comparator uses. The shadow copies the data register only when the count wraps from 255 to 0. A new code therefore never splits a period, but it may reach the pin up to one period late. A per-channel mode bit selects between the converter and a plain port latch. A converter channel follows the running count as soon as it is selected.

After reset every channel is in port mode and the latch holds 1, so all drivers are off. A clock-stop request turns every driver off and freezes the count and the shadows. Counting resumes from the same point when the request drops.

Top module: `pwm_dac_quad`

## Requirements
- R1: While `rst_n` is low and after it rises, all `pull_n` bits are 1. Mode bits reset to 0 (port), port latch bits to 1, data and shadow registers to 0, and the count and prescaler to 0.
- R2: A channel whose mode bit is 0 drives `pull_n[i]` equal to its port latch bit. A `port_we` cycle loads all latch bits from `port_bits` at that clock edge.
- R3: The PWM count advances by one, modulo 256, on every `PRESCALE`-th clock edge while `clk_stop` is low. With the default `PRESCALE` of 2 this is every second edge, so a period is 512 clocks.
- R4: A channel whose mode bit is 1 drives `pull_n[i]` low exactly while count < shadow code. Code 0 never pulls low. Code 255 pulls low on 255 of the 256 counts. Over one whole period the pin is low for code × `PRESCALE` clocks.
- R5: A shadow register takes its data register's value only at the edge where the count wraps from 255 to 0. A load made before that edge, even in the same period, keeps the old code on the pin until that edge. A load at that very edge waits one more period.
- R6: A `mode_we` cycle loads all mode bits from `mode_bits` (1 = converter, 0 = port). The first cycle after the edge already shows the new source, with the converter compared against the running count at once.
- R7: While `clk_stop` is high, every `pull_n` bit is 1, and the count, prescaler and shadows hold their values. When `clk_stop` drops, counting resumes from the held value.
- R8: A load with `ld_en` high writes `ld_data` into the data register of channel `ld_sel` (0 to 3). The other channels' data registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stop | input | 1 | Clock-stop request: drivers off, count frozen |
| ld_en | input | 1 | Data load strobe |
| ld_sel | input | 2 | Channel index for the load |
| ld_data | input | 8 | Code to load |
| mode_we | input | 1 | Mode write strobe |
| mode_bits | input | 4 | Per-channel mode, 1 = converter |
| port_we | input | 1 | Port latch write strobe |
| port_bits | input | 4 | Per-channel latch value, 1 = released |
| pull_n | output | 4 | Active-low pull-down enable per pin |

## Verification
A count that skips or stalls shows within one period as the wrong number of low clocks on every converter channel. A shadow that updates at the wrong moment shows in the cycle right after a mid-period load, because the pin follows the new code too early. A stuck mode or latch bit shows on the next cycle as a pin that ignores its source. A clock-stop that fails to freeze state shows as a phase jump when it is released. The bench tracks the expected count and shadows and compares every pin on every cycle, so any of these errors is reported within the period in which it happens.

// File: rtl/pwm_dac_quad.sv
module pwm_dac_quad #(
  parameter int NCH      = 4,
  parameter int W        = 8,
  parameter int PRESCALE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clk_stop,
  input  logic                   ld_en,
  input  logic [$clog2(NCH)-1:0] ld_sel,
  input  logic [W-1:0]           ld_data,
  input  logic                   mode_we,
  input  logic [NCH-1:0]         mode_bits,
  input  logic                   port_we,
  input  logic [NCH-1:0]         port_bits,
  output logic [NCH-1:0]         pull_n
);
  localparam int SW = $clog2(NCH);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [W-1:0]  CMAX = {W{1'b1}};
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0]  pre_q;
  logic [W-1:0]   cnt_q;
  logic [NCH-1:0] mode_q, port_q;
  logic [W-1:0]   data_q   [NCH];
  logic [W-1:0]   shadow_q [NCH];

  wire tick = !clk_stop && (pre_q == PLAST);
  wire wrap = tick && (cnt_q == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else if (!clk_stop) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      port_q <= '1;
    end else begin
      if (mode_we) mode_q <= mode_bits;
      if (port_we) port_q <= port_bits;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i]   <= '0;
        shadow_q[i] <= '0;
      end else begin
        if (ld_en && ld_sel == SW'(i)) data_q[i] <= ld_data;
        if (wrap) shadow_q[i] <= data_q[i];
      end
    end

    assign pull_n[i] = clk_stop  ? 1'b1 :
                       mode_q[i] ? !(cnt_q < shadow_q[i]) :
                                   port_q[i];

    p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && shadow_q[i] == '0) |-> pull_n[i]);
    p_full_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_stop && mode_q[i] && shadow_q[i] == CMAX && cnt_q != CMAX) |-> !pull_n[i]);
    p_shadow_wrap_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(shadow_q[i]));
  end

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> $stable(cnt_q));
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> &pull_n);
endmodule

// File: tb/pwm_dac_quad_tb.sv
`timescale 1ns/1ps
module pwm_dac_quad_tb_top;
  localparam int PS = 2;
  logic clk = 1'b0;
  logic rst_n;
  logic clk_stop = 0, ld_en = 0, mode_we = 0, port_we = 0;
  logic [1:0] ld_sel = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] mode_bits = '0, port_bits = '0;
  logic [3:0] pull_n;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dac_quad #(.NCH(4), .W(8), .PRESCALE(PS)) dut_i (
    .clk, .rst_n, .clk_stop, .ld_en, .ld_sel, .ld_data,
    .mode_we, .mode_bits, .port_we, .port_bits, .pull_n);

  // expected state, from the requirements
  int m_pre, m_cnt;
  int m_data [4], m_shadow [4];
  logic [3:0] m_mode, m_port;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_mode <= '0; m_port <= '1;
      for (int i = 0; i < 4; i++) begin m_data[i] <= 0; m_shadow[i] <= 0; end
    end else begin
      if (!clk_stop) begin
        if (m_pre == PS-1) begin
          m_pre <= 0;
          m_cnt <= (m_cnt + 1) % 256;
          if (m_cnt == 255) for (int i = 0; i < 4; i++) m_shadow[i] <= m_data[i];
        end else m_pre <= m_pre + 1;
      end
      if (ld_en) m_data[ld_sel] <= ld_data;
      if (mode_we) m_mode <= mode_bits;
      if (port_we) m_port <= port_bits;
    end
  end

  function automatic logic exp_pin(int i);
    if (clk_stop) return 1'b1;
    if (m_mode[i]) return !(m_cnt < m_shadow[i]);
    return m_port[i];
  endfunction

  task automatic chk(logic act, logic exp, string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk(pull_n[i], exp_pin(i), clk_stop ? "R7" : (m_mode[i] ? "R4" : "R2"));
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic load(int ch, int v);
    ld_en = 1; ld_sel = 2'(ch); ld_data = 8'(v);
    cyc();
    ld_en = 0;
  endtask

  task automatic set_mode(logic [3:0] m);
    mode_we = 1; mode_bits = m; cyc(); mode_we = 0;
  endtask

  task automatic set_port(logic [3:0] p);
    port_we = 1; port_bits = p; cyc(); port_we = 0;
  endtask

  initial begin
    int lows [4];
    void'($urandom(32'd1234));
    rst_n = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk(pull_n[i], 1'b1, "R1");
    rst_n = 1;
    run(5);
    for (int i = 0; i < 4; i++) chk(pull_n[i], 1'b1, "R1");

    // R2: port latch drives pins
    set_port(4'b0101);
    chk(pull_n[0], 1'b1, "R2"); chk(pull_n[1], 1'b0, "R2");
    chk(pull_n[3], 1'b0, "R2");

    // R8: each channel gets its own code
    load(0, 0); load(1, 255); load(2, 128); load(3, 1);
    set_mode(4'b1111);
    run(1100);
    for (int i = 0; i < 4; i++) lows[i] = 0;
    for (int k = 0; k < 256*PS; k++) begin
      cyc();
      for (int i = 0; i < 4; i++) if (!pull_n[i]) lows[i]++;
    end
    chk(lows[0] == 0,      1'b1, "R4 code0");
    chk(lows[1] == 255*PS, 1'b1, "R4 code255");
    chk(lows[2] == 128*PS, 1'b1, "R8 ch2");
    chk(lows[3] == 1*PS,   1'b1, "R8 ch3");
    chk(lows[0] == 0 && lows[1] == 510, 1'b1, "R3 period length");

    // R5: a mid-period load must not reach the pin before the wrap
    while (m_cnt != 10) cyc();
    load(2, 0);
    cyc();
    chk(pull_n[2], 1'b0, "R5 old code held");
    while (m_cnt != 255) cyc();
    while (m_cnt != 2) cyc();
    chk(pull_n[2], 1'b1, "R5 new code after wrap");
    load(2, 128);
    run(600);

    // R6: switching into converter mode acts at once
    set_mode(4'b1011);
    while (m_cnt != 40) cyc();
    set_mode(4'b1111);
    chk(pull_n[2], 1'b0, "R6 immediate waveform");

    // R7: clock stop releases pins and freezes count
    while (m_cnt != 60) cyc();
    clk_stop = 1;
    run(100);
    for (int i = 0; i < 4; i++) chk(pull_n[i], 1'b1, "R7");
    clk_stop = 0;
    cyc();
    chk(pull_n[2], 1'b0, "R7 resumed phase");

    // random mix
    for (int k = 0; k < 80; k++) begin
      case ($urandom % 5)
        0: load(int'($urandom % 4), int'($urandom % 256));
        1: set_mode(4'($urandom));
        2: set_port(4'($urandom));
        3: begin clk_stop = 1; run(1 + int'($urandom % 40)); clk_stop = 0; end
        default: run(1 + int'($urandom % 700));
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule